// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with APB Register Port

A 32-bit timer sits behind an APB slave port. Software writes a start value, either directly or through the reload register. Software also sets a few control bits that pick what advances the counter: every bus clock, every rising edge of an external pin, or bus clocks gated by that pin's level. The counter decrements once per tick. When it steps from one to zero, an interrupt status bit is set. This happens only if the interrupt is enabled. The status bit drives a level interrupt output until software clears it by writing a one.

After reaching zero the counter waits at zero for one more tick, then loads the reload value. A free-running timer with reload value N therefore interrupts every N+1 ticks. A reload value of zero parks the counter at zero with no further interrupts.

A read-only bank of identification bytes sits at the top of the 4 KiB window. The external pin passes through a two-flop synchronizer before use. Every bus access completes in its access phase with no wait states.

Top module: `apb_dcount_timer`

## Requirements
- R1: Byte offsets are 0x0 control, 0x4 counter value, 0x8 reload value and 0xC interrupt status. All four registers and the interrupt output are zero after reset.
- R2: The control register keeps only bits [3:0]: bit0 enable, bit1 pin-gate, bit2 pin-clock, bit3 interrupt enable. Reads return those bits, and bits [31:4] read as zero.
- R3: A tick needs bit0 set. With bit2 set, a tick is a rising edge of the synchronized pin; otherwise it is every clock. With bit1 set, no tick occurs while the synchronized pin is low.
- R4: Interrupt status bit0 is set only by a tick that takes the counter from 1 to 0 while control bit3 is set.
- R5: A tick at count zero loads the reload value, so after the 1-to-0 step the counter holds zero for one tick. With reload N and a clock tick, interrupts come N+1 cycles apart.
- R6: With a reload value of zero, the counter remains zero and no interrupt is raised.
- R7: A write to the reload register also loads that value into the counter.
- R8: A write to the value register loads the counter, and counting goes on from that value when enabled.
- R9: Writing 1 to status bit0 clears it, and writing 0 leaves it unchanged. The interrupt output equals the bit. When a set and a clear fall in the same cycle, the set wins.
- R10: Offsets 0xFD0 to 0xFFC return identification byte (offset-0xFD0)/4 in bits [7:0], with entry 0 = 0x5A, entry 1 = 0x11 and entry 11 = 0xA6. Writes there are ignored. Any other unmapped offset reads zero.
- R11: The ready output is always 1 and the error output always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| ext_i | input | 1 | External gate or count clock |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench measures the spacing between interrupts at reload 3. A design that reloads on the 1-to-0 tick itself, with no hold at zero, would interrupt every three cycles instead of four. A zero reload is run for many cycles; a design that treats reload-to-zero as a fresh terminal count would raise a spurious interrupt. Gate and pin-clock modes are checked by exact tick counts, which catch a missed synchronizer stage, level counting in place of edge counting, and an ignored gate. Clearing the status with a written zero, and writes to the identification bank, show that the wrong bit or a writable table gets caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam logic [11:0] OFF_CTRL = 12'h000;
  localparam logic [11:0] OFF_CNT  = 12'h004;
  localparam logic [11:0] OFF_RLD  = 12'h008;
  localparam logic [11:0] OFF_IRQ  = 12'h00C;
  localparam logic [11:0] OFF_ID_LO = 12'hFD0;
  localparam logic [11:0] OFF_ID_HI = 12'hFFC;
  localparam int ID_N = 12;

  typedef struct packed {
    logic irq_en;
    logic pin_clk;
    logic pin_gate;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] st_q;
  logic prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= 1'b0;
      else if (i == 0) st_q[i] <= d_i;
      else st_q[i] <= st_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= st_q[STAGES-1];
  end

  assign lvl_o  = st_q[STAGES-1];
  assign rise_o = st_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_cnt_i,
  input  logic         ld_rld_i,
  input  logic [W-1:0] wdata_i,
  input  logic         irq_en_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, rld_q;
  logic irq_q;
  logic hit;

  assign hit = tick_i && !ld_cnt_i && !ld_rld_i && cnt_q == W'(1) && irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (ld_rld_i) rld_q <= wdata_i;
      if (ld_rld_i || ld_cnt_i) cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (hit) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;

  AST_IRQ_FROM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ($past(cnt_q) == W'(1) && $past(tick_i) && $past(irq_en_i))); // R4
  AST_HOLD_THEN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == '0 && !ld_cnt_i && !ld_rld_i) |=> cnt_q == $past(rld_q)); // R5
  AST_NO_TICK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_cnt_i && !ld_rld_i) |=> $stable(cnt_q)); // R3
  AST_RELOAD_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rld_i |=> (cnt_q == $past(wdata_i) && rld_q == $past(wdata_i))); // R7
  AST_CLEAR_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !irq_q); // R9
endmodule

// File: rtl/tmr_id_rom.sv
module tmr_id_rom #(
  parameter int N = 12,
  parameter logic [8*N-1:0] TABLE = 96'hA6_19_73_4E_00_2B_C4_37_00_00_11_5A
) (
  input  logic [$clog2(N)-1:0] idx_i,
  output logic [7:0]           byte_o
);
  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < N; k++)
      if (idx_i == k[$clog2(N)-1:0]) byte_o = TABLE[8*k +: 8];
  end
endmodule

// File: rtl/apb_dcount_timer.sv
module apb_dcount_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              ext_i,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(ID_N);

  ctrl_t ctrl_q;
  logic wr, pin_lvl, pin_rise, tick;
  logic [11:0] off;
  logic [DATA_W-1:0] cnt, rld;
  logic irq;
  logic in_id;
  logic [11:0] id_off;
  logic [IDX_W-1:0] id_idx;
  logic [7:0] id_byte;

  assign off = 12'(paddr_i);
  assign wr  = psel_i && penable_i && pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr && off == OFF_CTRL) ctrl_q <= ctrl_t'(pwdata_i[3:0]);
  end

  tmr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(ext_i), .lvl_o(pin_lvl), .rise_o(pin_rise)
  );

  assign tick = ctrl_q.run
              && (ctrl_q.pin_clk ? pin_rise : 1'b1)
              && (ctrl_q.pin_gate ? pin_lvl : 1'b1);

  tmr_core #(.W(DATA_W)) i_core (
    .clk_i, .rst_ni,
    .tick_i  (tick),
    .ld_cnt_i(wr && off == OFF_CNT),
    .ld_rld_i(wr && off == OFF_RLD),
    .wdata_i (pwdata_i),
    .irq_en_i(ctrl_q.irq_en),
    .clr_i   (wr && off == OFF_IRQ && pwdata_i[0]),
    .cnt_o   (cnt),
    .rld_o   (rld),
    .irq_o   (irq)
  );

  assign in_id  = off >= OFF_ID_LO && off <= OFF_ID_HI;
  assign id_off = off - OFF_ID_LO;
  assign id_idx = id_off[IDX_W+1:2];

  tmr_id_rom #(.N(ID_N)) i_rom (.idx_i(id_idx), .byte_o(id_byte));

  always_comb begin
    prdata_o = '0;
    if (in_id) prdata_o = {24'h0, id_byte};
    else case (off)
      OFF_CTRL: prdata_o = {28'h0, ctrl_q};
      OFF_CNT:  prdata_o = cnt;
      OFF_RLD:  prdata_o = rld;
      OFF_IRQ:  prdata_o = {31'h0, irq};
      default:  prdata_o = '0;
    endcase
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
  assign irq_o     = irq;

  AST_GATE_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.pin_gate && !pin_lvl && !wr) |=> $stable(cnt)); // R3
  AST_PIN_CLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.pin_clk && !pin_rise && !wr) |=> $stable(cnt)); // R3
  AST_IDLE_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr) |=> ($stable(cnt) && $stable(rld))); // R2
  AST_BUS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_i |-> (pready_o && !pslverr_o)); // R11
endmodule

// File: tb/test_apb_dcount_timer.sv
`timescale 1ns/1ps
module test_apb_dcount_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0, ext = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq;
  int checks = 0, fails = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  apb_dcount_timer i_apb_dcount_timer (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .ext_i(ext), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string req);
    rdr(a, rd);
    chk(rd == e, req, rd, e);
  endtask

  task automatic t_reset;
    expect_rd(12'h000, 0, "R1 ctrl");
    expect_rd(12'h004, 0, "R1 value");
    expect_rd(12'h008, 0, "R1 reload");
    expect_rd(12'h00C, 0, "R1 status");
    chk(irq == 0, "R1 irq", irq, 0);
    chk(pready && !pslverr, "R11 bus", {pready, pslverr}, 2'b10);
  endtask

  task automatic t_ctrl;
    wr(12'h000, 32'hFFFF_FFFA);
    expect_rd(12'h000, 32'hA, "R2 ctrl bits");
    wr(12'h000, 0);
  endtask

  task automatic t_load;
    wr(12'h008, 5);
    expect_rd(12'h004, 5, "R7 value from reload");
    wr(12'h004, 9);
    expect_rd(12'h004, 9, "R8 value write");
    expect_rd(12'h008, 5, "R8 reload untouched");
  endtask

  task automatic t_period;
    wr(12'h008, 3);
    wr(12'h000, 32'h9);
    repeat (2) @(posedge clk);
    #1 chk(irq == 0, "R4 early", irq, 0);
    @(posedge clk); #1 chk(irq == 1, "R4 on 1->0", irq, 1);
    wr(12'h00C, 1);
    chk(irq == 0, "R9 cleared", irq, 0);
    @(posedge clk); #1 chk(irq == 0, "R5 hold at zero", irq, 0);
    @(posedge clk); #1 chk(irq == 1, "R5 period N+1", irq, 1);
    wr(12'h000, 0);
    wr(12'h00C, 0);
    expect_rd(12'h00C, 1, "R9 write 0 keeps");
    wr(12'h00C, 1);
    expect_rd(12'h00C, 0, "R9 write 1 clears");
  endtask

  task automatic t_no_irq_en;
    wr(12'h008, 2);
    wr(12'h000, 32'h1);
    repeat (20) @(posedge clk);
    #1 chk(irq == 0, "R4 no irq without enable", irq, 0);
    wr(12'h000, 0);
  endtask

  task automatic t_zero_reload;
    wr(12'h008, 0);
    wr(12'h000, 32'h9);
    repeat (20) @(posedge clk);
    #1 chk(irq == 0, "R6 no irq", irq, 0);
    expect_rd(12'h004, 0, "R6 parked");
  endtask

  task automatic t_value_run;
    wr(12'h004, 2);
    @(posedge clk); #1 chk(irq == 0, "R8 counting", irq, 0);
    @(posedge clk); #1 chk(irq == 1, "R8 continues to zero", irq, 1);
    wr(12'h000, 0);
    wr(12'h00C, 1);
  endtask

  task automatic t_gate;
    ext = 0;
    wr(12'h004, 100);
    wr(12'h000, 32'h3);
    repeat (10) @(posedge clk);
    wr(12'h000, 0);
    expect_rd(12'h004, 100, "R3 gate low");
    ext = 1;
    repeat (4) @(posedge clk);
    wr(12'h000, 32'h3);
    repeat (10) @(posedge clk);
    wr(12'h000, 0);
    expect_rd(12'h004, 88, "R3 gate high");
    ext = 0;
  endtask

  task automatic t_pin_clk;
    ext = 0;
    repeat (5) @(posedge clk);
    wr(12'h004, 4);
    wr(12'h000, 32'h5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext = 1;
      repeat (4) @(posedge clk);
      @(negedge clk); ext = 0;
      repeat (4) @(posedge clk);
    end
    wr(12'h000, 0);
    expect_rd(12'h004, 1, "R3 pin edges");
  endtask

  task automatic t_id;
    expect_rd(12'hFD0, 32'h5A, "R10 id0");
    expect_rd(12'hFD4, 32'h11, "R10 id1");
    expect_rd(12'hFFC, 32'hA6, "R10 id11");
    wr(12'hFD0, 32'hFF);
    expect_rd(12'hFD0, 32'h5A, "R10 write ignored");
    expect_rd(12'h010, 0, "R10 unmapped");
    expect_rd(12'hFCC, 0, "R10 below bank");
  endtask

  initial begin
    #10_000_000;
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_ctrl;
    t_load;
    t_period;
    t_no_irq_en;
    t_zero_reload;
    t_value_run;
    t_gate;
    t_pin_clk;
    t_id;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule